// File: doc/BRIEF.md
# Three-State Snoopy Line Coherence Controller

This block keeps the coherence state of a small direct-mapped set of cache lines in a bus-based snooping system. Each line is Invalid, Shared or Dirty. Local processor reads and writes move a line between these states and raise the bus transaction that the move needs. Coherent reads and writes snooped from other caches downgrade or invalidate local copies. A Dirty line that another cache reads is flushed. A remote write invalidates other copies and does not update them.

In every cycle the controller takes at most one local request and at most one snooped event, each with its own line index. When both name the same line, the snoop is applied first and the local request sees the state the snoop leaves. Bus requests and the flush request are combinational outputs in the cycle of the request, and the state register moves on the closing clock edge. Tag compare, data storage and bus arbitration belong to the surrounding cache.

Top module: `snoopy_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_line_state` shows the registered state of the line at `cpu_req_idx`, encoded Invalid = 2'b00, Shared = 2'b01, Dirty = 2'b10. The code 2'b11 never appears.
- R2: A local read (`cpu_req_valid`=1, `cpu_req_write`=0) of an Invalid line raises `bus_cread` in the same cycle. The line becomes Shared.
- R3: A local read of a Shared or Dirty line raises no bus request and leaves the state unchanged.
- R4: A local write (`cpu_req_write`=1) to an Invalid or Shared line raises `bus_cwrite` in the same cycle. The line becomes Dirty.
- R5: A local write to a Dirty line raises no bus request, and the line stays Dirty.
- R6: A snooped coherent write (`snp_valid`=1, `snp_write`=1) to a Shared or Dirty line makes it Invalid without a flush.
- R7: A snooped coherent read (`snp_write`=0) of a Dirty line raises `flush_req` in the same cycle, with `flush_idx` equal to the snooped index. The line becomes Shared.
- R8: A snoop on an Invalid line, or a coherent read snooped on a Shared line, changes no state and raises no flush.
- R9: When the snoop and the local request name the same line in one cycle, the snoop's transition is applied first. The local transition and its bus request then follow from the state the snoop leaves.
- R10: A snoop or local request on one line leaves every other line's state unchanged.
- R11: `cpu_ready` is high in the cycle after a cycle with `cpu_req_valid` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Local request present |
| cpu_req_write | input | 1 | Local request is a write (1) or a read (0) |
| cpu_req_idx | input | IDX_W | Line index of the local request |
| cpu_ready | output | 1 | Local request completed (one cycle after it) |
| cpu_line_state | output | 2 | Registered state of the line at cpu_req_idx |
| bus_cread | output | 1 | Coherent read request on the bus |
| bus_cwrite | output | 1 | Coherent write (invalidate) request on the bus |
| bus_idx | output | IDX_W | Line index of the bus request |
| snp_valid | input | 1 | Snooped bus event present |
| snp_write | input | 1 | Snooped event is a coherent write (1) or a coherent read (0) |
| snp_idx | input | IDX_W | Line index of the snooped event |
| flush_req | output | 1 | Flush of a Dirty line requested |
| flush_idx | output | IDX_W | Line index to flush |

## Verification
The bench builds the block with its default of eight lines and a three-bit index. That default lets snoops and local requests land on distinct lines in the same cycle, so isolation between lines can be checked, and lets line 7 check the full width of the flush index. Each line is driven through every state and every event. The same-line collisions cover all three orderings that matter: a read snooped on a Dirty line followed by a local write, a write snooped on a Dirty line followed by a local read, and a write snooped on a Shared line followed by a local write. A reset taken while lines are Dirty is also checked.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV   = 2'b00,
    LN_SHR   = 2'b01,
    LN_DIRTY = 2'b10
  } line_st_t;
endpackage

// File: rtl/coh_dec.sv
module coh_dec #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     hit
);
  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = en && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/coh_line.sv
module coh_line
  import coh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snp_hit,
  input  logic     snp_write,
  input  logic     cpu_hit,
  input  logic     cpu_write,
  output line_st_t st_q,
  output logic     flush,
  output logic     cread,
  output logic     cwrite
);
  line_st_t st_mid;
  line_st_t st_d;
  logic     upd_en;

  // snoop transition first, local transition on its result
  always_comb begin
    st_mid = st_q;
    flush  = 1'b0;
    if (snp_hit) begin
      if (snp_write) begin
        st_mid = LN_INV;
      end else if (st_q == LN_DIRTY) begin
        st_mid = LN_SHR;
        flush  = 1'b1;
      end
    end
  end

  always_comb begin
    st_d   = st_mid;
    cread  = 1'b0;
    cwrite = 1'b0;
    if (cpu_hit) begin
      if (!cpu_write) begin
        if (st_mid == LN_INV) begin
          st_d  = LN_SHR;
          cread = 1'b1;
        end
      end else begin
        st_d = LN_DIRTY;
        if (st_mid != LN_DIRTY) cwrite = 1'b1;
      end
    end
  end

  assign upd_en = snp_hit | cpu_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LN_INV;
    end else if (upd_en) begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/snoopy_coh_ctrl.sv
module snoopy_coh_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req_valid,
  input  logic             cpu_req_write,
  input  logic [IDX_W-1:0] cpu_req_idx,
  output logic             cpu_ready,
  output logic [1:0]       cpu_line_state,
  output logic             bus_cread,
  output logic             bus_cwrite,
  output logic [IDX_W-1:0] bus_idx,
  input  logic             snp_valid,
  input  logic             snp_write,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             flush_req,
  output logic [IDX_W-1:0] flush_idx
);
  logic [1:0]           rst_sync_q;
  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] snp_hit;
  logic [NUM_LINES-1:0] cpu_hit;
  logic [NUM_LINES-1:0] flush_v;
  logic [NUM_LINES-1:0] cread_v;
  logic [NUM_LINES-1:0] cwrite_v;
  line_st_t             st_arr [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  coh_dec #(.N(NUM_LINES), .IDX_W(IDX_W)) u_snp_dec (
    .en(snp_valid), .idx(snp_idx), .hit(snp_hit));
  coh_dec #(.N(NUM_LINES), .IDX_W(IDX_W)) u_cpu_dec (
    .en(cpu_req_valid), .idx(cpu_req_idx), .hit(cpu_hit));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    coh_line u_line (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .snp_hit  (snp_hit[g]),
      .snp_write(snp_write),
      .cpu_hit  (cpu_hit[g]),
      .cpu_write(cpu_req_write),
      .st_q     (st_arr[g]),
      .flush    (flush_v[g]),
      .cread    (cread_v[g]),
      .cwrite   (cwrite_v[g])
    );
  end

  assign flush_req  = |flush_v;
  assign bus_cread  = |cread_v;
  assign bus_cwrite = |cwrite_v;
  assign flush_idx  = snp_idx;
  assign bus_idx    = cpu_req_idx;
  assign cpu_line_state = st_arr[cpu_req_idx];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cpu_ready <= 1'b0;
    else             cpu_ready <= cpu_req_valid;
  end
endmodule

// File: rtl/snoopy_coh_ctrl_chk.sv
module snoopy_coh_ctrl_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             cpu_req_valid,
  input logic             cpu_req_write,
  input logic [IDX_W-1:0] cpu_req_idx,
  input logic             cpu_ready,
  input logic [1:0]       cpu_line_state,
  input logic             bus_cread,
  input logic             bus_cwrite,
  input logic             snp_valid,
  input logic             snp_write,
  input logic [IDX_W-1:0] snp_idx,
  input logic             flush_req
);
  logic same_line;
  assign same_line = snp_valid && (snp_idx == cpu_req_idx);

  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_line_state != 2'b11);
  // R11
  ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_req_valid |=> cpu_ready);
  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cpu_req_valid |=> !cpu_ready);
  // R2
  cread_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_cread |-> cpu_req_valid && !cpu_req_write);
  // R4
  cwrite_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_cwrite |-> cpu_req_valid && cpu_req_write);
  // R7
  flush_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_req |-> snp_valid && !snp_write);
  // R5
  dirty_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req_valid && cpu_req_write && !same_line && cpu_line_state == 2'b10)
    |-> !bus_cwrite);
  // R2
  inv_read_cread_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req_valid && !cpu_req_write && !same_line && cpu_line_state == 2'b00)
    |-> bus_cread);
  // R3
  valid_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req_valid && !cpu_req_write && !same_line && cpu_line_state != 2'b00)
    |-> !bus_cread);
endmodule

bind snoopy_coh_ctrl snoopy_coh_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_write (cpu_req_write),
  .cpu_req_idx   (cpu_req_idx),
  .cpu_ready     (cpu_ready),
  .cpu_line_state(cpu_line_state),
  .bus_cread     (bus_cread),
  .bus_cwrite    (bus_cwrite),
  .snp_valid     (snp_valid),
  .snp_write     (snp_write),
  .snp_idx       (snp_idx),
  .flush_req     (flush_req)
);

// File: tb/snoopy_coh_ctrl_tb.sv
module snoopy_coh_ctrl_tb;
  localparam int NL = 8;
  localparam int IW = 3;
  localparam int NV = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req_valid, cpu_req_write;
  logic [IW-1:0] cpu_req_idx;
  logic          cpu_ready;
  logic [1:0]    cpu_line_state;
  logic          bus_cread, bus_cwrite;
  logic [IW-1:0] bus_idx;
  logic          snp_valid, snp_write;
  logic [IW-1:0] snp_idx;
  logic          flush_req;
  logic [IW-1:0] flush_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  snoopy_coh_ctrl #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_idx(cpu_req_idx), .cpu_ready(cpu_ready),
    .cpu_line_state(cpu_line_state), .bus_cread(bus_cread),
    .bus_cwrite(bus_cwrite), .bus_idx(bus_idx),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_idx(snp_idx),
    .flush_req(flush_req), .flush_idx(flush_idx));

  // vector: {sv, sw, sidx[2:0], cv, cw, cidx[2:0], exp_cread, exp_cwrite, exp_flush, exp_state[1:0]}
  localparam logic [14:0] VEC [NV] = '{
    {1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 1'b1,1'b0,1'b0, 2'd0}, // R2 read I
    {1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 1'b0,1'b0,1'b0, 2'd1}, // R3 read S
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd0, 1'b0,1'b1,1'b0, 2'd1}, // R4 write S
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd0, 1'b0,1'b0,1'b0, 2'd2}, // R5 write D
    {1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 1'b0,1'b0,1'b0, 2'd2}, // R3 read D
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd1, 1'b0,1'b1,1'b0, 2'd0}, // R4 write I
    {1'b1,1'b0,3'd1, 1'b1,1'b0,3'd2, 1'b1,1'b0,1'b1, 2'd0}, // R7 R10 flush line1, read line2
    {1'b0,1'b0,3'd0, 1'b1,1'b0,3'd1, 1'b0,1'b0,1'b0, 2'd1}, // R7 line1 now S
    {1'b1,1'b1,3'd1, 1'b0,1'b0,3'd1, 1'b0,1'b0,1'b0, 2'd1}, // R6 cwrite on S
    {1'b0,1'b0,3'd0, 1'b0,1'b0,3'd1, 1'b0,1'b0,1'b0, 2'd0}, // R6 line1 I
    {1'b1,1'b1,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0, 2'd2}, // R6 cwrite on D
    {1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0, 2'd0}, // R6 line0 I
    {1'b1,1'b0,3'd2, 1'b0,1'b0,3'd2, 1'b0,1'b0,1'b0, 2'd1}, // R8 cread on S
    {1'b1,1'b1,3'd3, 1'b0,1'b0,3'd3, 1'b0,1'b0,1'b0, 2'd0}, // R8 cwrite on I
    {1'b1,1'b0,3'd3, 1'b0,1'b0,3'd2, 1'b0,1'b0,1'b0, 2'd1}, // R8 R10 cread on I, line2 still S
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd4, 1'b0,1'b1,1'b0, 2'd0}, // R4 line4 to D
    {1'b1,1'b0,3'd4, 1'b1,1'b1,3'd4, 1'b0,1'b1,1'b1, 2'd2}, // R9 cread D then write
    {1'b1,1'b1,3'd4, 1'b1,1'b0,3'd4, 1'b1,1'b0,1'b0, 2'd2}, // R9 cwrite D then read
    {1'b0,1'b0,3'd0, 1'b0,1'b0,3'd4, 1'b0,1'b0,1'b0, 2'd1}, // R9 line4 S
    {1'b1,1'b1,3'd2, 1'b1,1'b1,3'd2, 1'b0,1'b1,1'b0, 2'd1}, // R9 cwrite S then write
    {1'b0,1'b0,3'd0, 1'b0,1'b0,3'd2, 1'b0,1'b0,1'b0, 2'd2}  // R9 line2 D
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_idx = '0;
    snp_valid = 1'b0; snp_write = 1'b0; snp_idx = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all_invalid(input string req);
    for (int i = 0; i < NL; i++) begin
      cpu_req_idx = IW'(i);
      #1;
      chk(cpu_line_state == 2'd0, req, cpu_line_state, 0);
    end
    cpu_req_idx = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit prev_cv;
    rst_n = 1'b1;
    idle_inputs();
    do_reset();
    // R1 reset state
    check_all_invalid("R1");
    chk(cpu_ready == 1'b0, "R11", cpu_ready, 0);

    prev_cv = 1'b0;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      snp_valid     = VEC[v][14];
      snp_write     = VEC[v][13];
      snp_idx       = VEC[v][12:10];
      cpu_req_valid = VEC[v][9];
      cpu_req_write = VEC[v][8];
      cpu_req_idx   = VEC[v][7:5];
      #2;
      chk(cpu_line_state == VEC[v][1:0], $sformatf("state vec%0d", v), cpu_line_state, VEC[v][1:0]);
      chk(bus_cread == VEC[v][4], $sformatf("R2 cread vec%0d", v), bus_cread, VEC[v][4]);
      chk(bus_cwrite == VEC[v][3], $sformatf("R4 cwrite vec%0d", v), bus_cwrite, VEC[v][3]);
      chk(flush_req == VEC[v][2], $sformatf("R7 flush vec%0d", v), flush_req, VEC[v][2]);
      chk(cpu_ready == prev_cv, $sformatf("R11 ready vec%0d", v), cpu_ready, prev_cv);
      prev_cv = VEC[v][9];
    end

    // R7 flush index on highest line
    @(negedge clk);
    idle_inputs();
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_idx = 3'd7;
    #2;
    chk(bus_cwrite && bus_idx == 3'd7, "R4 line7", bus_idx, 7);
    @(negedge clk);
    idle_inputs();
    snp_valid = 1'b1; snp_write = 1'b0; snp_idx = 3'd7; cpu_req_idx = 3'd7;
    #2;
    chk(cpu_line_state == 2'd2, "R5 line7 dirty", cpu_line_state, 2);
    chk(flush_req == 1'b1, "R7 flush line7", flush_req, 1);
    chk(flush_idx == 3'd7, "R7 flush_idx", flush_idx, 7);
    chk(cpu_ready == 1'b1, "R11 ready after req", cpu_ready, 1);
    @(negedge clk);
    idle_inputs();
    cpu_req_idx = 3'd7;
    #2;
    chk(cpu_line_state == 2'd1, "R7 line7 shared", cpu_line_state, 1);
    chk(cpu_ready == 1'b0, "R11 ready idle", cpu_ready, 0);

    // R1 reset while lines hold Dirty and Shared
    do_reset();
    check_all_invalid("R1 mid reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule